// File: doc/BRIEF.md
# USB Host Interrupt Status Register

This block holds the host-side interrupt flags of a full/low-speed USB controller, together with the timers that watch the bus line state and raise some of those flags. Seven flags are sticky. Hardware sets them from one of two kinds of source. The first kind is one-cycle pulses from the transaction engine: token finished, frame-start threshold reached, and stall seen. The second kind is four line-state timers: attach, resume, idle and detach. Software clears a sticky flag by writing a word with a 1 in that flag's position. The eighth flag reports errors. It is not stored; it is the live OR of the error sources that the error-enable mask lets through.

A small register port sits beside the flags. It reads the status word, or reads and writes an 8-bit interrupt-enable register. The interrupt output is high whenever an enabled flag is high. The hold times are given in nanoseconds and converted to clock cycles from a clock-frequency parameter. A change of line state or of speed restarts every timer, and each timer fires at most once per unbroken run of one line state. After the detach flag fires, it stays blocked until a bus reset has ended.

Top module: `usbh_intstat`

## Requirements
- R1: After reset the status word and the enable register read zero, and `irq` is low. Bits 15:8 of every read are always zero. `reg_sel`=0 selects the status word and `reg_sel`=1 selects the enable register.
- R2: Status bit positions are: 7 stall, 6 attach, 5 resume, 4 idle, 3 token-done, 2 frame-start, 1 error, 0 detach. A one-cycle pulse on `stall_p`, `tok_done_p` or `sof_thr_p` sets bit 7, 3 or 2 respectively at that clock edge. The bit then stays set until software clears it.
- R3: A status write (`reg_wr`=1, `reg_sel`=0) clears each sticky bit whose data bit is 1 and leaves the others unchanged. If a hardware set and a write-1 clear hit the same bit at the same edge, the bit ends set.
- R4: Bit 1 equals the OR of `err_src & err_msk` in the same cycle. Writes to bit 1 have no effect on it.
- R5: Line encoding is `line_st[1]`=D+ and `line_st[0]`=D-, with SE0=00. Bit 6 sets at the ATTACH_NS-derived Nth consecutive rising edge at which `{low_spd, line_st}` is unchanged and `line_st` is not SE0.
- R6: The K state is 01 at full speed (`low_spd`=0) and 10 at low speed (`low_spd`=1). Bit 5 sets at the Nth consecutive rising edge with the K state held, using the same N as attach.
- R7: The J state is 10 at full speed and 01 at low speed. Bit 4 sets at the IDLE_NS-derived Mth consecutive rising edge with the J state held.
- R8: Bit 0 sets at the DETACH_NS-derived Nth consecutive edge of SE0 while `bus_rst_act` is low and detach is armed. Firing disarms detach. A falling edge of `bus_rst_act` re-arms it, and reset leaves it armed.
- R9: Each timer fires once per unbroken run of one line state. A cleared flag does not set again until the line state changes and qualifies anew.
- R10: A write with `reg_sel`=1 loads the enable register from data bits 7:0. `irq` is high exactly when some status bit and its enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_st | input | 2 | Synchronized line state, [1]=D+, [0]=D- |
| low_spd | input | 1 | 1 = low-speed bus, 0 = full-speed |
| tok_done_p | input | 1 | Token-processing-done pulse |
| sof_thr_p | input | 1 | Frame-start threshold pulse |
| stall_p | input | 1 | Stall-handshake pulse |
| err_src | input | ERR_W | Error source levels |
| err_msk | input | ERR_W | Error enable mask |
| bus_rst_act | input | 1 | Bus reset in progress |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = status word, 1 = interrupt-enable register |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data of the selected register |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with a 4 MHz clock parameter and a 6-bit error vector. With that clock the 2.5 µs attach, resume and detach holds come to 10 cycles and the 3 ms idle hold to 12,000 cycles. At these lengths every timer, including idle, can be driven to the exact edge where it fires and checked one edge before it. The random phase holds the line at SE1, which qualifies for attach but for none of the other timers. Over that steady bus it mixes pulses, write-1 clears, enable writes and error masks.

// File: rtl/usbh_irq_pkg.sv
package usbh_irq_pkg;

   localparam int unsigned NFLAG      = 8;
   localparam int unsigned BIT_DETACH = 0;
   localparam int unsigned BIT_ERR    = 1;
   localparam int unsigned BIT_SOF    = 2;
   localparam int unsigned BIT_TOK    = 3;
   localparam int unsigned BIT_IDLE   = 4;
   localparam int unsigned BIT_RESUME = 5;
   localparam int unsigned BIT_ATTACH = 6;
   localparam int unsigned BIT_STALL  = 7;

   typedef enum logic [1:0] {
      LN_SE0 = 2'b00,
      LN_DM  = 2'b01,
      LN_DP  = 2'b10,
      LN_SE1 = 2'b11
   } line_e;

   // convert a duration in ns to a cycle count, never below one
   function automatic int unsigned ns_to_cyc(longint unsigned hz, longint unsigned ns);
      longint unsigned c;
      c = (hz * ns) / 64'd1_000_000_000;
      if (c == 0) c = 1;
      return 32'(c);
   endfunction

endpackage

// File: rtl/usbh_line_timer.sv
module usbh_line_timer #(
   parameter int unsigned HOLD_CYC = 8,
   parameter int unsigned TAG_W    = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [TAG_W-1:0] tag,
   input  logic             qual,
   output logic             fire
);
   localparam int unsigned CW = $clog2(HOLD_CYC + 1);
   localparam logic [CW-1:0] HOLD_V = CW'(HOLD_CYC);

   generate
      if (HOLD_CYC < 1) begin : g_bad_hold
         $error("usbh_line_timer: HOLD_CYC must be at least 1");
      end
   endgenerate

   logic [TAG_W-1:0] tag_q;
   logic [CW-1:0]    run_q, run_nx;
   logic             done_q, changed, hit;

   assign changed = (tag != tag_q);
   // length of the current run, including this edge, saturating at the hold
   assign run_nx  = changed ? CW'(1) : ((run_q == HOLD_V) ? run_q : run_q + 1'b1);
   // the run reaches the hold length exactly once
   assign hit     = (run_nx == HOLD_V) && (changed || !done_q);
   assign fire    = hit && qual;

   always_ff @(posedge clk) begin
      if (rst) begin
         tag_q  <= '0;
         run_q  <= '0;
         done_q <= 1'b0;
      end else begin
         tag_q  <= tag;
         run_q  <= run_nx;
         done_q <= hit || (done_q && !changed);
      end
   end

endmodule

// File: rtl/usbh_detach_arm.sv
module usbh_detach_arm (
   input  logic clk,
   input  logic rst,
   input  logic bus_rst_act,
   input  logic fired,
   output logic armed
);
   logic brst_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         brst_q <= 1'b0;
         armed  <= 1'b1;
      end else begin
         brst_q <= bus_rst_act;
         if (brst_q && !bus_rst_act) armed <= 1'b1;
         else if (fired)             armed <= 1'b0;
      end
   end

endmodule

// File: rtl/usbh_flag_bank.sv
module usbh_flag_bank #(
   parameter int unsigned NF      = 8,
   parameter int unsigned LIVE    = 1,
   parameter int unsigned ERR_W   = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [NF-1:0]    set_v,
   input  logic [NF-1:0]    clr_v,
   input  logic [ERR_W-1:0] err_src,
   input  logic [ERR_W-1:0] err_msk,
   output logic [NF-1:0]    stat
);
   generate
      if (LIVE >= NF) begin : g_bad_live
         $error("usbh_flag_bank: LIVE index out of range");
      end
      for (genvar i = 0; i < NF; i++) begin : g_bit
         if (i == LIVE) begin : g_live
            logic unused_b;
            assign unused_b = set_v[i] ^ clr_v[i];
            assign stat[i]  = |(err_src & err_msk);
         end else begin : g_sticky
            logic q;
            always_ff @(posedge clk) begin
               if (rst) q <= 1'b0;
               else     q <= set_v[i] | (q & ~clr_v[i]);
            end
            assign stat[i] = q;
         end
      end
   endgenerate

endmodule

// File: rtl/usbh_intstat.sv
module usbh_intstat
   import usbh_irq_pkg::*;
#(
   parameter longint unsigned CLK_HZ    = 48_000_000,
   parameter int unsigned     ERR_W     = 8,
   parameter int unsigned     REG_W     = 16,
   parameter longint unsigned ATTACH_NS = 2_500,
   parameter longint unsigned IDLE_NS   = 3_000_000,
   parameter longint unsigned DETACH_NS = 2_500
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [1:0]       line_st,
   input  logic             low_spd,
   input  logic             tok_done_p,
   input  logic             sof_thr_p,
   input  logic             stall_p,
   input  logic [ERR_W-1:0] err_src,
   input  logic [ERR_W-1:0] err_msk,
   input  logic             bus_rst_act,
   input  logic             reg_wr,
   input  logic             reg_sel,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   output logic             irq
);
   localparam int unsigned ATT_CYC = ns_to_cyc(CLK_HZ, ATTACH_NS);
   localparam int unsigned IDL_CYC = ns_to_cyc(CLK_HZ, IDLE_NS);
   localparam int unsigned DET_CYC = ns_to_cyc(CLK_HZ, DETACH_NS);

   generate
      if (REG_W <= NFLAG) begin : g_bad_regw
         $error("usbh_intstat: REG_W must exceed the flag count");
      end
      if (ERR_W < 1) begin : g_bad_errw
         $error("usbh_intstat: ERR_W must be at least 1");
      end
      if (IDLE_NS <= ATTACH_NS) begin : g_bad_idle
         $error("usbh_intstat: idle hold must be longer than attach hold");
      end
   endgenerate

   logic [2:0]       tag;
   logic [1:0]       k_st, j_st;
   logic             att_f, res_f, idl_f, det_f, det_armed;
   logic [NFLAG-1:0] set_v, clr_v, stat;
   logic [NFLAG-1:0] ie_q;
   logic             unused_wd;

   assign tag  = {low_spd, line_st};
   assign k_st = low_spd ? LN_DP : LN_DM;
   assign j_st = low_spd ? LN_DM : LN_DP;

   usbh_line_timer #(.HOLD_CYC(ATT_CYC), .TAG_W(3)) u_att (
      .clk(clk), .rst(rst), .tag(tag),
      .qual(line_st != LN_SE0), .fire(att_f));

   usbh_line_timer #(.HOLD_CYC(ATT_CYC), .TAG_W(3)) u_res (
      .clk(clk), .rst(rst), .tag(tag),
      .qual(line_st == k_st), .fire(res_f));

   usbh_line_timer #(.HOLD_CYC(IDL_CYC), .TAG_W(3)) u_idl (
      .clk(clk), .rst(rst), .tag(tag),
      .qual(line_st == j_st), .fire(idl_f));

   usbh_line_timer #(.HOLD_CYC(DET_CYC), .TAG_W(3)) u_det (
      .clk(clk), .rst(rst), .tag(tag),
      .qual((line_st == LN_SE0) && det_armed && !bus_rst_act), .fire(det_f));

   usbh_detach_arm u_arm (
      .clk(clk), .rst(rst), .bus_rst_act(bus_rst_act),
      .fired(det_f), .armed(det_armed));

   always_comb begin
      set_v             = '0;
      set_v[BIT_STALL]  = stall_p;
      set_v[BIT_ATTACH] = att_f;
      set_v[BIT_RESUME] = res_f;
      set_v[BIT_IDLE]   = idl_f;
      set_v[BIT_TOK]    = tok_done_p;
      set_v[BIT_SOF]    = sof_thr_p;
      set_v[BIT_DETACH] = det_f;
   end

   assign clr_v = (reg_wr && !reg_sel) ? reg_wdata[NFLAG-1:0] : '0;

   usbh_flag_bank #(.NF(NFLAG), .LIVE(BIT_ERR), .ERR_W(ERR_W)) u_bank (
      .clk(clk), .rst(rst), .set_v(set_v), .clr_v(clr_v),
      .err_src(err_src), .err_msk(err_msk), .stat(stat));

   always_ff @(posedge clk) begin
      if (rst)                   ie_q <= '0;
      else if (reg_wr && reg_sel) ie_q <= reg_wdata[NFLAG-1:0];
   end

   assign unused_wd = ^reg_wdata[REG_W-1:NFLAG];
   assign reg_rdata = reg_sel ? REG_W'(ie_q) : REG_W'(stat);
   assign irq       = |(stat & ie_q);

endmodule

// File: rtl/usbh_intstat_chk.sv
module usbh_intstat_chk #(
   parameter int unsigned REG_W = 16
) (
   input logic             clk,
   input logic             rst,
   input logic [1:0]       line_st,
   input logic             low_spd,
   input logic             stall_p,
   input logic             tok_done_p,
   input logic             bus_rst_act,
   input logic             reg_wr,
   input logic             reg_sel,
   input logic [REG_W-1:0] reg_wdata,
   input logic [REG_W-1:0] reg_rdata,
   input logic [7:0]       stat
);
   logic stat0_q, brst_q, det_blk, det_rise;

   assign det_rise = stat[0] && !stat0_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         stat0_q <= 1'b0;
         brst_q  <= 1'b0;
         det_blk <= 1'b0;
      end else begin
         stat0_q <= stat[0];
         brst_q  <= bus_rst_act;
         if (brst_q && !bus_rst_act) det_blk <= 1'b0;
         else if (det_rise)          det_blk <= 1'b1;
      end
   end

   assert_upper_zero_R1: assert property (@(posedge clk) disable iff (rst)
      reg_rdata[REG_W-1:8] == '0);

   assert_stall_sets_R2: assert property (@(posedge clk) disable iff (rst)
      stall_p |=> stat[7]);

   assert_tok_sets_R2: assert property (@(posedge clk) disable iff (rst)
      tok_done_p |=> stat[3]);

   assert_w1c_R3: assert property (@(posedge clk) disable iff (rst)
      (reg_wr && !reg_sel && reg_wdata[3] && !tok_done_p) |=> !stat[3]);

   assert_keep_R3: assert property (@(posedge clk) disable iff (rst)
      (stat[2] && !(reg_wr && !reg_sel && reg_wdata[2])) |=> stat[2]);

   assert_attach_line_R5: assert property (@(posedge clk) disable iff (rst)
      $rose(stat[6]) |-> ($past(line_st) != 2'b00));

   assert_resume_k_R6: assert property (@(posedge clk) disable iff (rst)
      $rose(stat[5]) |-> ($past(line_st) == ($past(low_spd) ? 2'b10 : 2'b01)));

   assert_detach_rearm_R8: assert property (@(posedge clk) disable iff (rst)
      det_rise |-> !det_blk);

endmodule

bind usbh_intstat usbh_intstat_chk #(.REG_W(REG_W)) u_chk (
   .clk(clk), .rst(rst), .line_st(line_st), .low_spd(low_spd),
   .stall_p(stall_p), .tok_done_p(tok_done_p), .bus_rst_act(bus_rst_act),
   .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
   .reg_rdata(reg_rdata), .stat(stat));

// File: tb/sim_usbh_intstat.sv
module sim_usbh_intstat;
   localparam int CLK_PERIOD = 10;
   localparam longint unsigned HZ = 4_000_000;
   localparam int EW = 6;

   function automatic int cyc(longint unsigned ns);
      longint unsigned c;
      c = (HZ * ns) / 64'd1_000_000_000;
      return (c == 0) ? 1 : int'(c);
   endfunction

   localparam int ATT = cyc(2_500);
   localparam int IDL = cyc(3_000_000);
   localparam int DET = cyc(2_500);

   logic clk = 1'b0;
   logic rst;
   logic [1:0] line_st;
   logic low_spd, tok_done_p, sof_thr_p, stall_p, bus_rst_act;
   logic [EW-1:0] err_src, err_msk;
   logic reg_wr, reg_sel;
   logic [15:0] reg_wdata, reg_rdata;
   logic irq;

   int n_cmp = 0;
   int n_bad = 0;
   bit fin = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   usbh_intstat #(.CLK_HZ(HZ), .ERR_W(EW), .REG_W(16)) u0 (
      .clk(clk), .rst(rst), .line_st(line_st), .low_spd(low_spd),
      .tok_done_p(tok_done_p), .sof_thr_p(sof_thr_p), .stall_p(stall_p),
      .err_src(err_src), .err_msk(err_msk), .bus_rst_act(bus_rst_act),
      .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq));

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic stat_is(input string tag, input logic [15:0] e);
      reg_sel = 1'b0;
      #1;
      chk(tag, reg_rdata, e);
   endtask

   task automatic wr(input logic sel, input logic [15:0] d);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      tick(1);
      reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
   endtask

   function automatic logic [7:0] model_next(input logic [7:0] cur, input logic [7:0] setv,
                                             input logic clr_en, input logic [7:0] w);
      logic [7:0] n;
      n = clr_en ? (setv | (cur & ~w)) : (setv | cur);
      n[1] = 1'b0;
      return n;
   endfunction

   initial begin
      #(CLK_PERIOD * 150000);
      if (!fin) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] m_st, m_ie, view;
      logic errb;
      void'($urandom(32'd9137));
      rst = 1'b1; line_st = 2'b10; low_spd = 1'b0;
      tok_done_p = 0; sof_thr_p = 0; stall_p = 0; bus_rst_act = 0;
      err_src = '0; err_msk = '0; reg_wr = 0; reg_sel = 0; reg_wdata = '0;
      tick(4);
      rst = 1'b0;
      // R1 reset state
      stat_is("R1 status after reset", 16'h0000);
      reg_sel = 1'b1; #1; chk("R1 enable after reset", reg_rdata, 16'h0000);
      reg_sel = 1'b0;
      chk("R1 irq after reset", {15'b0, irq}, 16'h0000);

      // R5 attach on J at full speed
      tick(ATT - 1);
      stat_is("R5 attach one edge early", 16'h0000);
      tick(1);
      stat_is("R5 attach set", 16'h0040);
      // R7 idle on the same J run
      tick(IDL - ATT - 1);
      stat_is("R7 idle one edge early", 16'h0040);
      tick(1);
      stat_is("R7 idle set", 16'h0050);
      // R9 no refire on an unbroken run
      wr(1'b0, 16'hFFFF);
      tick(50);
      stat_is("R9 no refire after clear", 16'h0000);

      // R2 pulse inputs
      stall_p = 1; tick(1); stall_p = 0;
      stat_is("R2 stall pulse", 16'h0080);
      tok_done_p = 1; tick(1); tok_done_p = 0;
      sof_thr_p = 1; tick(1); sof_thr_p = 0;
      tick(5);
      stat_is("R2 flags held", 16'h008C);

      // R3 write-one-to-clear
      wr(1'b0, 16'h0008);
      stat_is("R3 clear bit3", 16'h0084);
      wr(1'b0, 16'h0000);
      stat_is("R3 zero write keeps", 16'h0084);
      stall_p = 1; reg_wr = 1; reg_sel = 0; reg_wdata = 16'h0080;
      tick(1);
      stall_p = 0; reg_wr = 0; reg_wdata = '0;
      stat_is("R3 set wins over clear", 16'h0084);
      wr(1'b0, 16'h0084);
      stat_is("R3 clear all", 16'h0000);

      // R4 error reduction
      err_src = 6'b000101; err_msk = 6'b000100;
      stat_is("R4 enabled error", 16'h0002);
      err_msk = 6'b000010;
      stat_is("R4 masked error", 16'h0000);
      err_msk = 6'b000100;
      wr(1'b0, 16'h0002);
      stat_is("R4 write ignored", 16'h0002);

      // R10 interrupt enable
      wr(1'b1, 16'h0002);
      reg_sel = 1'b1; #1; chk("R10 enable readback", reg_rdata, 16'h0002);
      reg_sel = 1'b0; #1;
      chk("R10 irq on enabled error", {15'b0, irq}, 16'h0001);
      wr(1'b1, 16'h0001);
      #1; chk("R10 irq off when disabled", {15'b0, irq}, 16'h0000);
      err_src = '0; err_msk = '0;

      // R6 resume, full speed K = 01
      line_st = 2'b01;
      tick(ATT - 1);
      stat_is("R6 fs resume early", 16'h0000);
      tick(1);
      stat_is("R6 fs resume set", 16'h0060);
      wr(1'b0, 16'h0060);
      // R6 resume, low speed K = 10
      line_st = 2'b10; low_spd = 1'b1;
      tick(ATT - 1);
      stat_is("R6 ls resume early", 16'h0000);
      tick(1);
      stat_is("R6 ls resume set", 16'h0060);
      wr(1'b0, 16'h0060);

      // R8 detach and re-arm
      line_st = 2'b00;
      tick(DET - 1);
      stat_is("R8 detach early", 16'h0000);
      tick(1);
      stat_is("R8 detach set", 16'h0001);
      #1; chk("R10 irq on detach", {15'b0, irq}, 16'h0001);
      wr(1'b0, 16'h0001);
      line_st = 2'b01; tick(3);
      line_st = 2'b00; tick(DET + 2);
      stat_is("R8 disarmed", 16'h0000);
      bus_rst_act = 1; tick(3); bus_rst_act = 0; tick(1);
      stat_is("R8 none during bus reset", 16'h0000);
      line_st = 2'b01; tick(2);
      line_st = 2'b00;
      tick(DET - 1);
      stat_is("R8 rearmed early", 16'h0000);
      tick(1);
      stat_is("R8 rearmed detach", 16'h0001);

      // random phase on a steady SE1 line
      line_st = 2'b11; low_spd = 1'b0;
      tick(ATT + 2);
      wr(1'b0, 16'hFFFF);
      wr(1'b1, 16'h0000);
      stat_is("R9 steady SE1", 16'h0000);
      m_st = '0; m_ie = '0;
      for (int k = 0; k < 600; k++) begin
         stall_p    = ($urandom % 4) == 0;
         tok_done_p = ($urandom % 4) == 0;
         sof_thr_p  = ($urandom % 4) == 0;
         reg_wr     = ($urandom % 3) == 0;
         reg_sel    = $urandom % 2;
         reg_wdata  = 16'($urandom);
         err_src    = EW'($urandom);
         err_msk    = EW'($urandom);
         m_st = model_next(m_st, {stall_p, 3'b000, tok_done_p, sof_thr_p, 2'b00},
                           reg_wr && !reg_sel, reg_wdata[7:0]);
         if (reg_wr && reg_sel) m_ie = reg_wdata[7:0];
         tick(1);
         errb = |(err_src & err_msk);
         view = m_st | {6'b0, errb, 1'b0};
         chk("R3 random readback", reg_rdata, reg_sel ? {8'h0, m_ie} : {8'h0, view});
         chk("R10 random irq", {15'b0, irq}, {15'b0, |(view & m_ie)});
      end
      stall_p = 0; tok_done_p = 0; sof_thr_p = 0; reg_wr = 0;

      fin = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule